// File: doc/BRIEF.md
# Numeric Coprocessor Status and Exception Control

This block keeps the 16-bit status word and the 16-bit control word of a floating-point coprocessor. The execution datapath sends it three things: one-cycle exception pulses from each operation, condition-code updates, and the current top-of-stack index and busy state. Six exception flags latch those pulses and stay set until a clear command arrives.

Each flag has a mask bit in the control word. When any flag is set and its mask bit is 0, the block raises the error-summary bit and the interrupt request. Software loads the control word through a write port and reads the status word back. The high byte of the status word is also brought out separately so the host can copy it into its flags register.

The rounding, precision and infinity-mode fields are only stored and exported. Nothing in this block acts on them.

Top module: `fpu_stat_ctrl`

## Requirements
- R1: After reset, `sw_o` is 0x0000, `cw_o` is 0x037F (all six exceptions masked) and `irq_o` is 0.
- R2: Each bit of `exc_i` is ORed into a sticky flag at every clock edge, and the flag reads in `sw_o` from the following cycle. The bit order is: bit0 invalid, bit1 denormal, bit2 zero-divide, bit3 overflow, bit4 underflow, bit5 precision. A set flag stays set until a clear.
- R3: `clr_exc_i` zeroes all six flags and the summary bit at the next edge. Exception pulses that arrive in the same cycle as the clear are still recorded.
- R4: `sw_o[7]` (error summary) is 1 exactly when some flag `sw_o[i]` (i = 0..5) is 1 and its mask bit `cw_o[i]` is 0. A mask bit of 1 removes that flag's contribution.
- R5: `irq_o` equals the error-summary bit in every cycle.
- R6: When `cw_we_i` is high, `cw_i` appears on `cw_o` after the edge. The summary bit and `irq_o` reflect the new masks in that same cycle, and the flags are left unchanged.
- R7: The condition codes sit at `sw_o[8]`=C0, `[9]`=C1, `[10]`=C2 and `[14]`=C3, taken from `cc_i[0..3]`. They load only when `cc_we_i` is high and hold their value otherwise.
- R8: `sw_o[13:11]` and `sw_o[15]` show `top_i` and `busy_i` as sampled at the previous edge.
- R9: `sw_hi_o` always equals `sw_o[15:8]`.
- R10: `prec_o` = `cw_o[9:8]`, `round_o` = `cw_o[11:10]` and `inf_ctl_o` = `cw_o[12]`. `sw_o[6]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_i | input | 6 | Exception pulses from the current operation |
| clr_exc_i | input | 1 | Clear all exception flags |
| cc_we_i | input | 1 | Condition-code write enable |
| cc_i | input | 4 | New condition codes C3..C0 |
| top_i | input | 3 | Current top-of-stack index |
| busy_i | input | 1 | Execution unit busy |
| cw_we_i | input | 1 | Control-word load strobe |
| cw_i | input | 16 | Control word to load |
| cw_o | output | 16 | Stored control word |
| sw_o | output | 16 | Assembled status word |
| sw_hi_o | output | 8 | High byte of the status word for host flags |
| irq_o | output | 1 | Coprocessor interrupt request |
| round_o | output | 2 | Rounding-mode field |
| prec_o | output | 2 | Precision field |
| inf_ctl_o | output | 1 | Infinity-mode bit |

## Verification
The bench unmasks a flag that is already set, to show that the summary rises in the same cycle as the new control word. A design that registered the summary would show it one cycle late. A clear that arrives together with a new pulse is checked to keep that pulse, which catches a clear that simply wins. Condition codes are driven with new values while the write enable is low, which exposes a register that loads every cycle. The bench also remasks every flag while they stay set, which catches a summary that sticks instead of following the masks.

// File: rtl/fpu_sc_pkg.sv
package fpu_sc_pkg;
  localparam int unsigned EXC_N  = 6;
  localparam int unsigned CC_N   = 4;
  localparam int unsigned TOP_W  = 3;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = WORD_W / 2;
  localparam logic [WORD_W-1:0] CW_RST = 16'h037F;

  // status word bit positions
  localparam int unsigned SW_ES   = 7;
  localparam int unsigned SW_TOP  = 11;
  localparam int unsigned SW_BUSY = 15;
  // control word field positions
  localparam int unsigned CW_PREC = 8;
  localparam int unsigned CW_RND  = 10;
  localparam int unsigned CW_INF  = 12;
endpackage

// File: rtl/fpu_exc_flags.sv
module fpu_exc_flags
  import fpu_sc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EXC_N-1:0] exc_i,
  input  logic             clr_i,
  input  logic [EXC_N-1:0] mask_i,
  output logic [EXC_N-1:0] flags_o,
  output logic             es_o
);
  logic [EXC_N-1:0] flag_q;
  logic [EXC_N-1:0] live;

  for (genvar i = 0; i < EXC_N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= 1'b0;
      else         flag_q[i] <= (flag_q[i] & ~clr_i) | exc_i[i];
    end
    assign live[i] = flag_q[i] & ~mask_i[i];
  end

  // summary is combinational so a control-word load takes effect at once
  assign es_o    = |live;
  assign flags_o = flag_q;
endmodule

// File: rtl/fpu_ctrl_word.sv
module fpu_ctrl_word
  import fpu_sc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] d_i,
  output logic [WORD_W-1:0] cw_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cw_o <= CW_RST;
    else if (we_i) cw_o <= d_i;
  end
endmodule

// File: rtl/fpu_stat_word.sv
module fpu_stat_word
  import fpu_sc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cc_we_i,
  input  logic [CC_N-1:0]   cc_i,
  input  logic [TOP_W-1:0]  top_i,
  input  logic              busy_i,
  input  logic [EXC_N-1:0]  flags_i,
  input  logic              es_i,
  output logic [WORD_W-1:0] sw_o
);
  logic [CC_N-1:0]  cc_q;
  logic [TOP_W-1:0] top_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q   <= '0;
      top_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (cc_we_i) cc_q <= cc_i;
      top_q  <= top_i;
      busy_q <= busy_i;
    end
  end

  always_comb begin
    sw_o                      = '0;
    sw_o[EXC_N-1:0]           = flags_i;
    sw_o[SW_ES]               = es_i;
    sw_o[10:8]                = cc_q[2:0];
    sw_o[SW_TOP+:TOP_W]       = top_q;
    sw_o[14]                  = cc_q[3];
    sw_o[SW_BUSY]             = busy_q;
  end
endmodule

// File: rtl/fpu_stat_ctrl.sv
module fpu_stat_ctrl
  import fpu_sc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EXC_N-1:0]  exc_i,
  input  logic              clr_exc_i,
  input  logic              cc_we_i,
  input  logic [CC_N-1:0]   cc_i,
  input  logic [TOP_W-1:0]  top_i,
  input  logic              busy_i,
  input  logic              cw_we_i,
  input  logic [WORD_W-1:0] cw_i,
  output logic [WORD_W-1:0] cw_o,
  output logic [WORD_W-1:0] sw_o,
  output logic [BYTE_W-1:0] sw_hi_o,
  output logic              irq_o,
  output logic [1:0]        round_o,
  output logic [1:0]        prec_o,
  output logic              inf_ctl_o
);
  logic [WORD_W-1:0] cw_q;
  logic [EXC_N-1:0]  flags;
  logic              es;
  logic [WORD_W-1:0] sw;

  fpu_ctrl_word u_cw (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cw_we_i),
    .d_i   (cw_i),
    .cw_o  (cw_q)
  );

  fpu_exc_flags u_exc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .exc_i  (exc_i),
    .clr_i  (clr_exc_i),
    .mask_i (cw_q[EXC_N-1:0]),
    .flags_o(flags),
    .es_o   (es)
  );

  fpu_stat_word u_sw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cc_we_i(cc_we_i),
    .cc_i   (cc_i),
    .top_i  (top_i),
    .busy_i (busy_i),
    .flags_i(flags),
    .es_i   (es),
    .sw_o   (sw)
  );

  assign cw_o      = cw_q;
  assign sw_o      = sw;
  assign sw_hi_o   = sw[WORD_W-1:BYTE_W];
  assign irq_o     = es;
  assign round_o   = cw_q[CW_RND+:2];
  assign prec_o    = cw_q[CW_PREC+:2];
  assign inf_ctl_o = cw_q[CW_INF];
endmodule

// File: rtl/fpu_stat_ctrl_chk.sv
module fpu_stat_ctrl_chk
  import fpu_sc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [EXC_N-1:0]  exc_i,
  input logic              clr_exc_i,
  input logic              cc_we_i,
  input logic [TOP_W-1:0]  top_i,
  input logic              cw_we_i,
  input logic [WORD_W-1:0] cw_i,
  input logic [WORD_W-1:0] cw_o,
  input logic [WORD_W-1:0] sw_o
);
  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_exc_i |=> ((sw_o[5:0] & $past(sw_o[5:0])) == $past(sw_o[5:0])));

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_i != '0) |=> ((sw_o[5:0] & $past(exc_i)) == $past(exc_i)));

  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_exc_i && exc_i == '0) |=> (sw_o[5:0] == '0 && !sw_o[SW_ES]));

  assert_summary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_o[SW_ES] == |(sw_o[5:0] & ~cw_o[5:0]));

  assert_cw_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_we_i |=> (cw_o == $past(cw_i)));

  assert_cc_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cc_we_i |=> ($stable(sw_o[10:8]) && $stable(sw_o[14])));

  assert_top_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sw_o[13:11] == $past(top_i)));
endmodule

bind fpu_stat_ctrl fpu_stat_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .exc_i    (exc_i),
  .clr_exc_i(clr_exc_i),
  .cc_we_i  (cc_we_i),
  .top_i    (top_i),
  .cw_we_i  (cw_we_i),
  .cw_i     (cw_i),
  .cw_o     (cw_o),
  .sw_o     (sw_o)
);

// File: tb/fpu_stat_ctrl_test.sv
`timescale 1ns/1ps
module fpu_stat_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  exc_i = '0;
  logic        clr_exc_i = 1'b0;
  logic        cc_we_i = 1'b0;
  logic [3:0]  cc_i = '0;
  logic [2:0]  top_i = '0;
  logic        busy_i = 1'b0;
  logic        cw_we_i = 1'b0;
  logic [15:0] cw_i = '0;
  logic [15:0] cw_o, sw_o;
  logic [7:0]  sw_hi_o;
  logic        irq_o, inf_ctl_o;
  logic [1:0]  round_o, prec_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  fpu_stat_ctrl uut (.*);

  // reference model state
  logic [5:0]  m_flags = '0;
  logic [15:0] m_cw = 16'h037F;
  logic [3:0]  m_cc = '0;
  logic [2:0]  m_top = '0;
  logic        m_busy = 1'b0;

  logic [15:0] q_sw[$];
  logic [15:0] q_cw[$];
  string       q_req[$];

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_sw();
    logic es;
    es = |(m_flags & ~m_cw[5:0]);
    return {m_busy, m_cc[3], m_top, m_cc[2:0], es, 1'b0, m_flags};
  endfunction

  task automatic step(input logic [5:0] exc, input logic clr, input logic ccwe,
                      input logic [3:0] cc, input logic [2:0] top, input logic busy,
                      input logic cwwe, input logic [15:0] cw, input string req);
    @(negedge clk_i);
    exc_i = exc; clr_exc_i = clr; cc_we_i = ccwe; cc_i = cc;
    top_i = top; busy_i = busy; cw_we_i = cwwe; cw_i = cw;
    m_flags = (clr ? 6'b0 : m_flags) | exc;
    if (cwwe) m_cw = cw;
    if (ccwe) m_cc = cc;
    m_top = top; m_busy = busy;
    q_sw.push_back(exp_sw());
    q_cw.push_back(m_cw);
    q_req.push_back(req);
  endtask

  // monitor: compare one expected item per clock, just after the edge
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (q_sw.size() > 0) begin
        logic [15:0] esw, ecw;
        string r;
        esw = q_sw.pop_front();
        ecw = q_cw.pop_front();
        r   = q_req.pop_front();
        check(r, sw_o, esw);
        check({r, "/R9"}, {8'h00, sw_hi_o}, {8'h00, esw[15:8]});
        check({r, "/R5"}, {15'h0, irq_o}, {15'h0, esw[7]});
        check({r, "/R6"}, cw_o, ecw);
        check({r, "/R10"}, {11'h0, inf_ctl_o, round_o, prec_o},
              {11'h0, ecw[12], ecw[11:10], ecw[9:8]});
      end
    end
  end

  initial begin
    #40000;
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 sw", sw_o, 16'h0000);
    check("R1 cw", cw_o, 16'h037F);
    check("R1 irq", {15'h0, irq_o}, 16'h0000);
    rst_ni = 1'b1;

    // R2: invalid pulse while masked, summary stays low (R4)
    step(6'b000001, 0, 0, 4'h0, 3'd0, 0, 0, 16'h0, "R2 invalid masked R4");
    step(6'b000000, 0, 0, 4'h0, 3'd0, 0, 0, 16'h0, "R2 sticky");
    step(6'b100100, 0, 0, 4'h0, 3'd7, 1, 0, 16'h0, "R2 or R8");
    step(6'b000010, 0, 0, 4'h0, 3'd5, 0, 0, 16'h0, "R2 denormal R8");
    // R6: unmask invalid only, summary rises with new cw
    step(6'b000000, 0, 0, 4'h0, 3'd5, 0, 1, 16'h037E, "R6 unmask R4");
    // R10: rounding 11, precision 00, infinity 1
    step(6'b000000, 0, 0, 4'h0, 3'd2, 1, 1, 16'h1C7E, "R10 fields");
    // R7: condition codes load, then held while enable low
    step(6'b000000, 0, 1, 4'b1010, 3'd2, 1, 0, 16'h0, "R7 load");
    step(6'b000000, 0, 0, 4'b0101, 3'd3, 0, 0, 16'h0, "R7 hold");
    step(6'b000000, 0, 1, 4'b0101, 3'd3, 0, 0, 16'h0, "R7 reload");
    // R3: clear with no pulses
    step(6'b000000, 1, 0, 4'h0, 3'd3, 0, 0, 16'h0, "R3 clear");
    step(6'b000000, 0, 0, 4'h0, 3'd3, 0, 0, 16'h0, "R3 after clear");
    // R3: clear together with a zero-divide pulse keeps the pulse
    step(6'b001001, 0, 0, 4'h0, 3'd1, 0, 0, 16'h0, "R2 preload");
    step(6'b000100, 1, 0, 4'h0, 3'd1, 0, 0, 16'h0, "R3 clear plus pulse");
    // R4: unmask zero-divide then remask everything
    step(6'b000000, 0, 0, 4'h0, 3'd1, 0, 1, 16'h007B, "R4 zdiv unmasked");
    step(6'b000000, 0, 0, 4'h0, 3'd1, 0, 1, 16'h037F, "R4 remask");
    step(6'b111111, 0, 0, 4'h0, 3'd6, 1, 0, 16'h0, "R4 all masked");
    step(6'b000000, 0, 0, 4'h0, 3'd6, 1, 1, 16'h0340, "R4 all unmasked");
    step(6'b000000, 1, 0, 4'h0, 3'd0, 0, 0, 16'h0, "R3 clear drops irq");

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule